// File: doc/BRIEF.md
# Paced Buffer-to-Consumer Byte Streamer

This block moves a run of bytes out of a sector buffer and hands them to a downstream consumer one at a time. Each byte goes out at a fixed programmable interval. Software works through a small register file. It first writes a 5-bit pointer to select a register, then writes data into that register. The pointer steps forward by itself after each ordinary data write. Software sets the output-enable bit, loads a 16-bit count split over two byte registers, and writes the start register.

The first byte is offered on the cycle after the start write. After that, each byte is offered one byte period after the previous one was taken. The byte period is four clocks times a multiplier register. The buffer itself sits outside the block. The block drives the read address and takes the read data back combinationally.

If the consumer refuses a byte, the run halts where it stands. It resumes only when software writes the start register again. The engine sends one byte more than the loaded count and finishes when the count underflows. Two active-low flags report the state: a busy flag and an end-of-run interrupt flag, which software clears through an acknowledge register.

Top module: `paced_xfer_engine`

## Requirements
- R1: After reset, statusOut reads 0xFF, outValid is 0, countOut is 0, bufAddr is 0 and the multiplier is 6.
- R2: A regSelWr write loads the pointer from regWrData[4:0]. A regDataWr write goes to the selected register: 0 = control (bit 0 is output enable), 1 = count low byte, 2 = count high byte, 3 = start, 4 = acknowledge, 5 = multiplier (bits 3:0, where 0 is stored as 1). After each data write the pointer increments, except when it selects register 3 or register 4.
- R3: A start write made while output enable is 0 is ignored. No byte is offered, statusOut stays as it was, and countOut and bufAddr keep their values.
- R4: A start write made while output enable is 1 clears statusOut bit 0 (busy, active-low). The first byte is offered in the cycle after the write.
- R5: Once a byte is accepted (outValid and outReady both high at a clock edge), the next byte is offered exactly 4*M cycles later, where M is the multiplier.
- R6: Each accepted byte lowers countOut by one. A loaded count N gives N+1 bytes, and after the last one countOut reads 0xFFFF.
- R7: outData equals the buffer data at bufAddr. bufAddr rises by one per accepted byte and wraps modulo 2^BUF_AW.
- R8: When the final byte is accepted, statusOut bit 0 goes to 1 and bit 1 (end interrupt, active-low) goes to 0, and no further byte is offered.
- R9: A byte that is offered but refused stops the run. No further byte is offered, busy stays 0, and countOut and bufAddr hold their values. A new start write resumes the run from the remaining count.
- R10: A write to the acknowledge register sets statusOut bit 1 to 1. If the final-byte acceptance falls in the same cycle, bit 1 ends at 0.
- R11: A multiplier write made during a run does not restart it. The new value sets the gap that follows the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSelWr | input | 1 | Load register pointer from regWrData |
| regDataWr | input | 1 | Write regWrData to the selected register |
| regWrData | input | 8 | Register write data |
| bufAddr | output | BUF_AW | Buffer read address |
| bufData | input | 8 | Buffer read data for bufAddr |
| outValid | output | 1 | A byte is offered |
| outData | output | 8 | Offered byte |
| outReady | input | 1 | Consumer takes the offered byte |
| statusOut | output | 8 | Bit 0 busy (active-low), bit 1 end interrupt (active-low), others 1 |
| countOut | output | 16 | Current byte count |

## Verification
Two events can land on the same clock edge: the acceptance of the final byte, which pulls the interrupt flag low, and a software write to the acknowledge register, which pulls it high. The bench provokes this by parking the pointer on the acknowledge register during a run and then clearing the flag early. It then issues a second acknowledge write in the very cycle the consumer takes the last byte. Once that edge has passed, the flag must read pending, because the completion wins. A lone acknowledge write made afterwards must clear the flag.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
  localparam int PTR_W = 5;
  localparam logic [PTR_W-1:0] ADDR_CTRL   = 5'd0;
  localparam logic [PTR_W-1:0] ADDR_CNT_LO = 5'd1;
  localparam logic [PTR_W-1:0] ADDR_CNT_HI = 5'd2;
  localparam logic [PTR_W-1:0] ADDR_START  = 5'd3;
  localparam logic [PTR_W-1:0] ADDR_ACK    = 5'd4;
  localparam logic [PTR_W-1:0] ADDR_MULT   = 5'd5;

  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic step;
  } dpStrobe_t;
endpackage

// File: rtl/pxe_ctrl.sv
module pxe_ctrl
  import pxe_pkg::*;
#(
  parameter int MULT_W     = 4,
  parameter int BASE_STEP  = 4,
  parameter int MULT_RESET = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selWr,
  input  logic       dataWr,
  input  logic [7:0] wrData,
  input  logic       outReady,
  input  logic       countZero,
  output dpStrobe_t  strobe,
  output logic       outValid,
  output logic [7:0] statusOut
);
  localparam int TIMER_W = $clog2(BASE_STEP * (2 ** MULT_W));

  logic [PTR_W-1:0]   ptr;
  logic               outEn;
  logic [MULT_W-1:0]  mult;
  logic               active;
  logic               busyN;
  logic               irqN;
  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] reloadVal;
  logic wrHit, wrStart, wrAck, start, accept, finish;

  assign wrHit     = dataWr & ~selWr;
  assign wrStart   = wrHit && (ptr == ADDR_START);
  assign wrAck     = wrHit && (ptr == ADDR_ACK);
  assign start     = wrStart & outEn;
  assign outValid  = active && (timer == '0);
  assign accept    = outValid & outReady;
  assign finish    = accept & countZero;
  assign reloadVal = TIMER_W'(BASE_STEP * int'(mult) - 1);

  assign strobe.loadLo = wrHit && (ptr == ADDR_CNT_LO);
  assign strobe.loadHi = wrHit && (ptr == ADDR_CNT_HI);
  assign strobe.step   = accept;
  assign statusOut     = {6'h3F, irqN, busyN};

  // register pointer and plain registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr   <= '0;
      outEn <= 1'b0;
      mult  <= MULT_W'(MULT_RESET);
    end else begin
      if (selWr) ptr <= wrData[PTR_W-1:0];
      else if (dataWr && ptr != ADDR_START && ptr != ADDR_ACK) ptr <= ptr + 1'b1;
      if (wrHit && ptr == ADDR_CTRL) outEn <= wrData[0];
      if (wrHit && ptr == ADDR_MULT)
        mult <= (wrData[MULT_W-1:0] == '0) ? MULT_W'(1) : wrData[MULT_W-1:0];
    end
  end

  // run sequencer and pacing timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      busyN  <= 1'b1;
      timer  <= '0;
    end else if (start) begin
      active <= 1'b1;
      busyN  <= 1'b0;
      timer  <= '0;
    end else if (active) begin
      if (outValid) begin
        if (!outReady) active <= 1'b0;
        else if (countZero) begin
          active <= 1'b0;
          busyN  <= 1'b1;
        end else timer <= reloadVal;
      end else begin
        timer <= timer - 1'b1;
      end
    end
  end

  // end-of-run flag: completion outranks acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqN <= 1'b1;
    else if (finish) irqN <= 1'b0;
    else if (wrAck) irqN <= 1'b1;
  end
endmodule

// File: rtl/pxe_datapath.sv
module pxe_datapath
  import pxe_pkg::*;
#(
  parameter int BUF_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        wrData,
  output logic              countZero,
  output logic [15:0]       countOut,
  output logic [BUF_AW-1:0] bufAddr
);
  logic [15:0]       cnt;
  logic [BUF_AW-1:0] addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      addr <= '0;
    end else begin
      if (strobe.loadLo) cnt[7:0]  <= wrData;
      if (strobe.loadHi) cnt[15:8] <= wrData;
      if (!strobe.loadLo && !strobe.loadHi && strobe.step) cnt <= cnt - 16'd1;
      if (strobe.step) addr <= addr + 1'b1;
    end
  end

  assign countZero = (cnt == 16'd0);
  assign countOut  = cnt;
  assign bufAddr   = addr;
endmodule

// File: rtl/paced_xfer_engine.sv
module paced_xfer_engine
  import pxe_pkg::*;
#(
  parameter int BUF_AW     = 6,
  parameter int MULT_W     = 4,
  parameter int BASE_STEP  = 4,
  parameter int MULT_RESET = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSelWr,
  input  logic              regDataWr,
  input  logic [7:0]        regWrData,
  output logic [BUF_AW-1:0] bufAddr,
  input  logic [7:0]        bufData,
  output logic              outValid,
  output logic [7:0]        outData,
  input  logic              outReady,
  output logic [7:0]        statusOut,
  output logic [15:0]       countOut
);
  dpStrobe_t strobe;
  logic      countZero;

  pxe_ctrl #(
    .MULT_W(MULT_W), .BASE_STEP(BASE_STEP), .MULT_RESET(MULT_RESET)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .selWr(regSelWr), .dataWr(regDataWr),
    .wrData(regWrData), .outReady(outReady), .countZero(countZero),
    .strobe(strobe), .outValid(outValid), .statusOut(statusOut)
  );

  pxe_datapath #(.BUF_AW(BUF_AW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .countZero(countZero), .countOut(countOut), .bufAddr(bufAddr)
  );

  assign outData = bufData;
endmodule

// File: rtl/pxe_checker.sv
module pxe_checker #(
  parameter int BUF_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              regDataWr,
  input logic [BUF_AW-1:0] bufAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [7:0]        statusOut,
  input logic [15:0]       countOut
);
  AST_OFFER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !statusOut[0]); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady |=> bufAddr == $past(bufAddr) + 1'b1); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !regDataWr |=> countOut == $past(countOut) - 16'd1); // R6
  AST_PACE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && countOut != 16'd0 && !regDataWr |=> !outValid); // R5
  AST_STALL_HALT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !regDataWr |=> !outValid && !statusOut[0]); // R9
  AST_END_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && countOut == 16'd0 && !regDataWr |=> statusOut[1:0] == 2'b01 && !outValid); // R8
  AST_ACK_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[1]) |-> $past(regDataWr)); // R10
endmodule

bind paced_xfer_engine pxe_checker #(.BUF_AW(BUF_AW)) chk_i (
  .clk(clk), .rstN(rstN), .regDataWr(regDataWr), .bufAddr(bufAddr),
  .outValid(outValid), .outReady(outReady), .statusOut(statusOut),
  .countOut(countOut)
);

// File: tb/paced_xfer_engine_tb_top.sv
module paced_xfer_engine_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSelWr = 1'b0, regDataWr = 1'b0, outReady = 1'b0;
  logic [7:0] regWrData = '0;
  logic [AW-1:0] bufAddr;
  logic [7:0] bufData, outData, statusOut;
  logic outValid;
  logic [15:0] countOut;

  int nChecks = 0, nFails = 0;
  int expAddr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] bufModel(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  assign bufData = bufModel(int'(bufAddr));

  paced_xfer_engine #(.BUF_AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .regSelWr(regSelWr), .regDataWr(regDataWr),
    .regWrData(regWrData), .bufAddr(bufAddr), .bufData(bufData),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .statusOut(statusOut), .countOut(countOut)
  );

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drv(input bit sel, input bit data, input int d);
    @(negedge clk);
    regSelWr = sel; regDataWr = data; regWrData = 8'(d);
    @(posedge clk);
    #1 regSelWr = 0; regDataWr = 0;
  endtask

  // load multiplier, enable, count, then start via the auto-incremented pointer
  task automatic setup(input int n, input int m);
    drv(1, 0, 5); drv(0, 1, m);
    drv(1, 0, 0); drv(0, 1, 1); drv(0, 1, n & 255); drv(0, 1, n >> 8);
    @(negedge clk);
    chkEq("R2", "count via pointer", countOut, n);
    drv(0, 1, 0); // pointer now at start register
  endtask

  task automatic runXfer(input int n, input int m, input int stallIdx, input bit collide, input int newM);
    int sinceTrig = 0, sinceAcc = 0, got = 0, guard = 0, gapExp;
    bit fin = 0, first = 1, stalled = 0, seenV;
    while (!fin) begin
      @(negedge clk);
      regSelWr = 0; regDataWr = 0; outReady = 0;
      sinceTrig++; sinceAcc++; guard++;
      if (guard > 20000) begin
        chkEq("R5", "run hung", 0, 1); fin = 1;
      end else if (got == n + 1) begin
        chkEq("R8", "busy after end", statusOut[0], 1);
        chkEq("R8", "irq after end", statusOut[1], 0);
        chkEq("R8", "no offer after end", outValid, 0);
        chkEq("R6", "count after end", countOut, 16'hFFFF);
        fin = 1;
      end else begin
        if (collide && got == 0 && sinceTrig == 1) begin regSelWr = 1; regWrData = 8'd4; end
        if (collide && got == 1 && sinceAcc == 1) begin regDataWr = 1; regWrData = 8'd0; end
        if (collide && got == 1 && sinceAcc == 2)
          chkEq("R10", "ack clears flag", statusOut[1], 1);
        if (newM != 0 && got == 1 && sinceAcc == 1) begin regSelWr = 1; regWrData = 8'd5; end
        if (newM != 0 && got == 1 && sinceAcc == 2) begin regDataWr = 1; regWrData = 8'(newM); end
        if (outValid) begin
          chkEq("R7", "data", outData, bufModel(expAddr));
          chkEq("R7", "address", bufAddr, expAddr);
          chkEq("R6", "count at offer", countOut, n - got);
          chkEq("R4", "busy during run", statusOut[0], 0);
          gapExp = (newM != 0 && got >= 2) ? 4 * newM : 4 * m;
          if (first) chkEq("R4", "first offer delay", sinceTrig, 1);
          else chkEq((newM != 0) ? "R11" : "R5", "gap", sinceAcc, gapExp);
          if (got == stallIdx && !stalled) begin
            stalled = 1; seenV = 0;
            repeat (8 * m) begin
              @(negedge clk);
              if (outValid) seenV = 1;
            end
            chkEq("R9", "no offer when stalled", seenV, 0);
            chkEq("R9", "busy held", statusOut[0], 0);
            chkEq("R9", "count held", countOut, n - got);
            chkEq("R9", "address held", bufAddr, expAddr);
            regDataWr = 1; regWrData = 8'd0;
            sinceTrig = 0; first = 1;
          end else begin
            outReady = 1; got++; sinceAcc = 0; first = 0;
            expAddr = (expAddr + 1) % (1 << AW);
            if (collide && got == n + 1) begin regDataWr = 1; regWrData = 8'd0; end
          end
        end
      end
    end
    regDataWr = 0; regSelWr = 0; outReady = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'd4417));
    repeat (3) @(negedge clk);
    chkEq("R1", "status", statusOut, 8'hFF);
    chkEq("R1", "valid", outValid, 0);
    chkEq("R1", "count", countOut, 0);
    chkEq("R1", "address", bufAddr, 0);
    rstN = 1;

    // start while disabled (R3); pointer goes 0 -> 1 -> 2 -> 3
    drv(1, 0, 0); drv(0, 1, 0); drv(0, 1, 3); drv(0, 1, 0);
    drv(0, 1, 0);
    seen = 0;
    repeat (40) begin @(negedge clk); if (outValid) seen = 1; end
    chkEq("R3", "no offer", seen, 0);
    chkEq("R3", "status", statusOut, 8'hFF);
    chkEq("R3", "count kept", countOut, 3);
    chkEq("R3", "address kept", bufAddr, 0);

    // default multiplier 6 (R1, R5)
    drv(1, 0, 0); drv(0, 1, 1); drv(0, 1, 3); drv(0, 1, 0); drv(0, 1, 0);
    runXfer(3, 6, -1, 0, 0);

    // wrap across buffer end, minimum multiplier (R7)
    setup(20, 1);  runXfer(20, 1, -1, 0, 0);
    // stall then resume (R9)
    setup(6, 2);   runXfer(6, 2, 3, 0, 0);
    // stall on the first byte
    setup(2, 1);   runXfer(2, 1, 0, 0, 0);
    // multiplier change mid-run (R11)
    setup(5, 3);   runXfer(5, 3, -1, 0, 7);
    // acknowledge collides with final acceptance (R10)
    setup(2, 2);   runXfer(2, 2, -1, 1, 0);
    drv(0, 1, 0);  // pointer still at acknowledge register (R2)
    @(negedge clk);
    chkEq("R10", "lone ack", statusOut[1], 1);
    // single byte run
    setup(0, 1);   runXfer(0, 1, -1, 0, 0);

    for (int i = 0; i < 12; i++) begin
      int n = $urandom_range(0, 40);
      int m = $urandom_range(1, 8);
      int s = ($urandom_range(0, 3) == 0) ? $urandom_range(0, n) : -1;
      setup(n, m);
      runXfer(n, m, s, 0, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule